// File: doc/BRIEF.md
# Associative Tag Table with Recency Tracking

This block is a sixteen-entry, fully associative tag table. A 32-bit search key is compared against every stored tag in a single cycle. The registered 9-bit result word appears one clock later. When a valid entry matches, the word gives that entry's index and the four state bits that software stored with it. When nothing matches, the word gives the index of the entry that has gone longest without use, so the caller can pick a slot to replace without a second query.

Software fills entries through a write port that takes an index, a tag and a state value. It can inspect any entry through a combinational read-back port, and it can invalidate the whole table with a single clear command. Recency is kept as a full ordering of all sixteen entries. A write moves the written entry to the most recently used position, and so does a lookup that hits. A lookup that misses leaves the order as it was.

Top module: `cam_lru_table`

## Requirements
- R1: After reset every entry is invalid and the recency order runs from entry 0 (least recent) to entry 15 (most recent), so a first lookup misses and reports index 0.
- R2: A lookup presented with `lkp_en` high produces `res_vld` high, together with its result word, exactly one clock later. `res_vld` is low in any cycle that follows a cycle without a lookup.
- R3: The result word is laid out as bits 8:5 state, bit 4 hit flag, bits 3:0 index.
- R4: On a hit the index is that of the matching entry and the state field holds that entry's stored state bits. The state bits never take part in matching.
- R5: On a miss the index is that of the least recently used entry and the state field reads zero.
- R6: An invalid entry never hits, whatever its stored tag is.
- R7: When several valid entries match the key, the lowest-numbered one is reported.
- R8: A lookup hit makes the matched entry most recently used. A miss leaves the recency order unchanged.
- R9: A write sets the entry valid, stores its tag and state, and makes it most recently used. When a write and a lookup occur in the same cycle, the lookup sees the contents from before the write and only the write updates recency.
- R10: Clear-all makes every entry invalid and leaves the recency order unchanged. A write in the same cycle still leaves its own entry valid.
- R11: The read-back port returns the tag, state and valid bit of the entry selected by `rd_idx` in the same cycle, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_en | input | 1 | Lookup request |
| lkp_key | input | 32 | Search key |
| res_vld | output | 1 | Result word valid, one cycle after lookup |
| res_word | output | 9 | {state[3:0], hit, index[3:0]} |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 4 | Entry to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | Software state bits to store |
| clr_all | input | 1 | Invalidate every entry |
| rd_idx | input | 4 | Entry to read back |
| rd_tag | output | 32 | Stored tag of selected entry |
| rd_state | output | 4 | Stored state of selected entry |
| rd_valid | output | 1 | Valid bit of selected entry |

## Verification
Lookups are tried against an empty table, against single matches, and against duplicate tags written to several slots. The empty-table case separates the reset recency order from victim selection, and the duplicate-tag case tests the lowest-index rule. Long random runs draw keys and tags from a small pool, so hits, misses and duplicates are all frequent, and the recency order is reshuffled by both writes and hits. These runs show whether a miss names the true oldest entry after many promotions. Cycles that combine a write with a lookup, or a clear with a write, separate the old-contents rule from the write-wins rule. Keys that equal the tags of invalid entries show whether matching ignores stale tags.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int CAM_N  = 16;
    localparam int KEY_W  = 32;
    localparam int ST_W   = 4;
    localparam int IDX_W  = $clog2(CAM_N);
    localparam int RES_W  = ST_W + 1 + IDX_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [KEY_W-1:0] key_t;
    typedef logic [ST_W-1:0]  st_t;

    typedef struct packed {
        st_t  state;
        logic hit;
        idx_t idx;
    } cam_res_t;

    // lowest set bit position of a per-entry flag vector
    function automatic idx_t lowest_set(input logic [CAM_N-1:0] v);
        idx_t r;
        r = '0;
        for (int i = CAM_N - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  key_t wr_tag,
    input  st_t  wr_state,
    input  logic clr_all,
    input  key_t key,
    output logic hit,
    output idx_t hit_idx,
    output st_t  hit_state,
    input  idx_t rd_idx,
    output key_t rd_tag,
    output st_t  rd_state,
    output logic rd_valid
);
    key_t             tag_q   [CAM_N];
    st_t              state_q [CAM_N];
    logic [CAM_N-1:0] valid_q;
    logic [CAM_N-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < CAM_N; i++) begin
                tag_q[i]   <= '0;
                state_q[i] <= '0;
            end
        end else begin
            if (clr_all) valid_q <= '0;
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
                state_q[wr_idx] <= wr_state;
            end
        end
    end

    for (genvar g = 0; g < CAM_N; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == key);
    end

    assign hit       = |match;
    assign hit_idx   = lowest_set(match);
    assign hit_state = state_q[hit_idx];

    assign rd_tag   = tag_q[rd_idx];
    assign rd_state = state_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // R10: clear without write leaves nothing valid
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_en) |=> (valid_q == '0));
    // R9: a write leaves its entry valid with the written tag
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/cam_recency.sv
module cam_recency
    import cam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic touch_en,
    input  idx_t touch_idx,
    output idx_t lru_idx
);
    // rank 0 = least recently used, CAM_N-1 = most recently used
    idx_t             rank_q [CAM_N];
    logic [CAM_N-1:0] is_lru;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CAM_N; i++) rank_q[i] <= idx_t'(i);
        end else if (touch_en) begin
            for (int i = 0; i < CAM_N; i++) begin
                if (idx_t'(i) == touch_idx)
                    rank_q[i] <= idx_t'(CAM_N - 1);
                else if (rank_q[i] > rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] - 1'b1;
            end
        end
    end

    for (genvar g = 0; g < CAM_N; g++) begin : g_lru
        assign is_lru[g] = (rank_q[g] == '0);
    end

    assign lru_idx = lowest_set(is_lru);

    // R8: ranks stay a permutation, so exactly one oldest entry
    a_r8_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(is_lru) == 1);
    // R8: a touched entry becomes most recent
    a_r8_touch_to_top: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (rank_q[$past(touch_idx)] == idx_t'(CAM_N - 1)));
    // R8: without a touch the victim does not move
    a_r8_idle_keeps_victim: assert property (@(posedge clk) disable iff (rst)
        !touch_en |=> $stable(lru_idx));
endmodule

// File: rtl/cam_lru_table.sv
module cam_lru_table
    import cam_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lkp_en,
    input  logic [KEY_W-1:0] lkp_key,
    output logic             res_vld,
    output logic [RES_W-1:0] res_word,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_tag,
    input  logic [ST_W-1:0]  wr_state,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_tag,
    output logic [ST_W-1:0]  rd_state,
    output logic             rd_valid
);
    logic     hit;
    idx_t     hit_idx;
    st_t      hit_state;
    idx_t     lru_idx;
    logic     touch_en;
    idx_t     touch_idx;
    cam_res_t res_d;
    cam_res_t res_q;

    cam_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_state  (wr_state),
        .clr_all   (clr_all),
        .key       (lkp_key),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_state (hit_state),
        .rd_idx    (rd_idx),
        .rd_tag    (rd_tag),
        .rd_state  (rd_state),
        .rd_valid  (rd_valid)
    );

    // write wins recency when it coincides with a lookup
    assign touch_en  = wr_en || (lkp_en && hit);
    assign touch_idx = wr_en ? wr_idx : hit_idx;

    cam_recency u_recency (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    always_comb begin
        res_d.hit   = hit;
        res_d.idx   = hit ? hit_idx : lru_idx;
        res_d.state = hit ? hit_state : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res_q   <= '0;
        end else begin
            res_vld <= lkp_en;
            if (lkp_en) res_q <= res_d;
        end
    end

    assign res_word = res_q;

    // R2: a result is only flagged after a lookup
    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(lkp_en));
    // R5: a miss carries no state bits
    a_r5_miss_no_state: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_q.hit) |-> (res_q.state == '0));
    // R5: a miss names the victim seen at lookup time
    a_r5_miss_is_victim: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_q.hit) |-> (res_q.idx == $past(lru_idx)));
endmodule

// File: tb/cam_lru_table_bench.sv
module cam_lru_table_bench;
    import cam_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             lkp_en;
    logic [KEY_W-1:0] lkp_key;
    logic             res_vld;
    logic [RES_W-1:0] res_word;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [KEY_W-1:0] wr_tag;
    logic [ST_W-1:0]  wr_state;
    logic             clr_all;
    logic [IDX_W-1:0] rd_idx;
    logic [KEY_W-1:0] rd_tag;
    logic [ST_W-1:0]  rd_state;
    logic             rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cam_lru_table u_cam_lru_table (.*);

    // reference model: order[0] oldest, order[CAM_N-1] newest
    logic [KEY_W-1:0] m_tag   [CAM_N];
    logic [ST_W-1:0]  m_st    [CAM_N];
    logic             m_val   [CAM_N];
    int               m_order [CAM_N];

    function automatic logic [RES_W-1:0] expect_res(input logic [KEY_W-1:0] k);
        for (int i = 0; i < CAM_N; i++)
            if (m_val[i] && m_tag[i] == k)
                return {m_st[i], 1'b1, IDX_W'(i)};
        return {ST_W'(0), 1'b0, IDX_W'(m_order[0])};
    endfunction

    function automatic void promote(input int e);
        int p = 0;
        for (int i = 0; i < CAM_N; i++) if (m_order[i] == e) p = i;
        for (int i = p; i < CAM_N - 1; i++) m_order[i] = m_order[i+1];
        m_order[CAM_N-1] = e;
    endfunction

    function automatic void check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    task automatic step(input bit lk, input logic [KEY_W-1:0] k,
                        input bit wr, input int wi, input logic [KEY_W-1:0] wt,
                        input logic [ST_W-1:0] ws, input bit clr, input int ri,
                        input string req);
        logic [RES_W-1:0] exp_r;
        lkp_en = lk; lkp_key = k;
        wr_en = wr; wr_idx = IDX_W'(wi); wr_tag = wt; wr_state = ws;
        clr_all = clr; rd_idx = IDX_W'(ri);
        exp_r = expect_res(k);
        @(posedge clk);
        if (wr) promote(wi);
        else if (lk && exp_r[IDX_W]) promote(int'(exp_r[IDX_W-1:0]));
        if (clr) for (int i = 0; i < CAM_N; i++) m_val[i] = 1'b0;
        if (wr) begin m_val[wi] = 1'b1; m_tag[wi] = wt; m_st[wi] = ws; end
        @(negedge clk);
        check({req, " R2 valid"}, 64'(res_vld), 64'(lk));
        if (lk) check({req, " result"}, 64'(res_word), 64'(exp_r));
        check("R11 readback", {rd_tag, rd_state, 3'b0, rd_valid},
              {m_tag[ri], m_st[ri], 3'b0, m_val[ri]});
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < CAM_N; i++) begin
            m_tag[i] = '0; m_st[i] = '0; m_val[i] = 1'b0; m_order[i] = i;
        end
        rst = 1'b1; lkp_en = 0; lkp_key = '0; wr_en = 0; wr_idx = '0;
        wr_tag = '0; wr_state = '0; clr_all = 0; rd_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset res_vld", 64'(res_vld), 64'd0);
        check("R1 reset valid", 64'(rd_valid), 64'd0);
        step(1, 32'h0, 0, 0, '0, '0, 0, 3, "R6 stale zero tag");
        step(1, 32'hDEAD_0001, 0, 0, '0, '0, 0, 0, "R1 first victim");
        check("R1 victim index 0", 64'(res_word), 64'h000);
        // R4 / R3 hit on entry 5 with state 9
        step(0, '0, 1, 5, 32'hA5A5_0000, 4'h9, 0, 5, "R9 write");
        step(1, 32'hA5A5_0000, 0, 0, '0, '0, 0, 5, "R4 hit");
        check("R3 layout", 64'(res_word), 64'({4'h9, 1'b1, 4'h5}));
        step(1, 32'h1111_1111, 0, 0, '0, '0, 0, 0, "R5 miss");
        // R9 write promotes entry 0, so victim becomes 1
        step(0, '0, 1, 0, 32'hB0B0_B0B0, 4'h2, 0, 0, "R9 write");
        step(1, 32'h2222_2222, 0, 0, '0, '0, 0, 0, "R9 victim moves");
        // R7 duplicate tag in entry 9
        step(0, '0, 1, 9, 32'hA5A5_0000, 4'h3, 0, 9, "R7 dup write");
        step(1, 32'hA5A5_0000, 0, 0, '0, '0, 0, 9, "R7 lowest index");
        // R9 write and lookup in the same cycle
        step(1, 32'hC0C0_C0C0, 1, 2, 32'hC0C0_C0C0, 4'h7, 0, 2, "R9 old contents");
        step(1, 32'hC0C0_C0C0, 0, 0, '0, '0, 0, 2, "R9 now hits");
        // R8 miss does not reorder
        step(1, 32'h3333_3333, 0, 0, '0, '0, 0, 0, "R8 miss");
        step(1, 32'h4444_4444, 0, 0, '0, '0, 0, 0, "R8 miss same victim");
        // R10 clear with simultaneous write
        step(0, '0, 1, 4, 32'hD0D0_D0D0, 4'h1, 1, 4, "R10 clear+write");
        step(1, 32'hC0C0_C0C0, 0, 0, '0, '0, 0, 2, "R10 R6 cleared miss");
        step(1, 32'hD0D0_D0D0, 0, 0, '0, '0, 0, 4, "R10 write survives");
        // random phase over a small tag pool
        for (int n = 0; n < 3000; n++) begin
            logic [KEY_W-1:0] pk, pt;
            int r;
            r  = int'($urandom_range(99));
            pk = 32'h5000_0000 + 32'($urandom_range(9));
            pt = 32'h5000_0000 + 32'($urandom_range(9));
            step(r < 60, pk, (r % 3) == 0, int'($urandom_range(CAM_N-1)), pt,
                 ST_W'($urandom), $urandom_range(63) == 0,
                 int'($urandom_range(CAM_N-1)), "R4 R5 R7 R8 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule